// File: doc/BRIEF.md
# Multi-pass multiply-accumulate pipeline

This block is the multiply-accumulate execute path of an integer core. It accepts one operation per issue. Each operation carries a 3-bit class code, two 32-bit multiplicands, a 64-bit accumulator and two control bits: one that enables accumulation and one that requests condition flags. The path has three stages and a writeback stage. The first stage holds an operation for one, two or three cycles, depending on how many passes through the multiplier array the class needs. While it holds an operation, the block refuses new work.

The issue side is a valid/ready interface. An operation is taken on a rising edge where `iss_valid` and `iss_ready` are both high. Offering an operation while `iss_ready` is low has no effect, and the bench may keep the same operation on the inputs until it is taken. `busy` is the inverse of `iss_ready`. The writeback side has no ready input. It runs in lockstep with the rest of the execute path, so a result beat is presented for exactly one cycle with `wb_valid` high. A 64-bit result takes two consecutive beats, with the lower word first and `wb_upper` marking the second beat.

In the timing below, "N edges after acceptance" means the output is visible in the cycle that follows the N-th rising edge counted from the accepting edge. P is the pass count of the class.

Top module: `mac_pipe`

## Requirements
- R1: During reset and just after it, `iss_ready` is 1 and `busy`, `wb_valid` and `flag_valid` are 0.
- R2: After an operation is accepted, `busy` is high and `iss_ready` is low for exactly P cycles. P is 1 for classes 3 and 4, 2 for classes 0, 5, 6 and 7, and 3 for classes 1 and 2.
- R3: An operation offered while `busy` is high is ignored. It produces no writeback beat and does not alter the operation already held.
- R4: Class 0 returns the low 32 bits of a*b plus, when accumulation is enabled, `iss_acc[31:0]`. It is one beat with `wb_upper`=0, presented 4 edges after acceptance.
- R5: Classes 1 (unsigned) and 2 (signed) return the 64-bit product a*b plus, when accumulation is enabled, the 64-bit `iss_acc`. The lower word is presented 4 edges after acceptance with `wb_upper`=0, and the upper word follows on the next cycle with `wb_upper`=1.
- R6: Class 3 returns the signed product of the two low halves, a[15:0]*b[15:0]. Class 4 returns that product plus the signed product of the high halves, a[31:16]*b[31:16]. Either class adds `iss_acc[31:0]` when accumulation is enabled. The result is one 32-bit beat presented 3 edges after acceptance.
- R7: Class 5 sign-extends the signed low-half product to 64 bits and adds the 64-bit `iss_acc` when accumulation is enabled. The lower word is presented 3 edges after acceptance and the upper word 4 edges after.
- R8: Class 6 returns the upper 32 bits of the signed 64-bit product. Class 7 returns the upper 32 bits of that product plus 0x8000_0000. Both ignore the accumulate bit, and both present one beat 4 edges after acceptance.
- R9: When flags are requested, `flag_valid` is high on the final beat of the result and only there. `flag_n` is then the most significant bit of the whole result (bit 63 for classes 1, 2 and 5, bit 31 otherwise). `flag_z` is 1 when the whole result is zero. Without a flag request, `flag_valid` stays 0.
- R10: Operations accepted in the first ready cycle after a previous one produce their results in issue order, with no overlapping beats. No beat appears at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Operation offered |
| iss_ready | output | 1 | Operation can be taken this cycle |
| iss_class | input | 3 | Operation class code 0..7 |
| iss_accum | input | 1 | Add the accumulator |
| iss_setflags | input | 1 | Produce N and Z flags |
| iss_a | input | W | First multiplicand |
| iss_b | input | W | Second multiplicand |
| iss_acc | input | 2W | Accumulator; low word used by 32-bit classes |
| busy | output | 1 | First stage is recirculating |
| wb_valid | output | 1 | Result beat present |
| wb_upper | output | 1 | Beat is the upper word of a 64-bit result |
| wb_data | output | W | Result word |
| flag_valid | output | 1 | Flags are valid on this beat |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The hardest situation to reach from the ports is the one where the upper word of a two-beat result sits right next to the first beat of the operation behind it. That only happens when the next operation is taken on the very first ready cycle and has a short pass count. To get there, the stimulus holds each offer on the inputs until it is taken, so every acceptance lands on the first free edge. Random class sequences with few idle gaps are mixed with directed long-then-halfword pairs. Offers made during recirculation come from operations held on the inputs and from deliberate offers of a different class right after a three-pass operation.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    C_WORD  = 3'd0,
    C_ULONG = 3'd1,
    C_SLONG = 3'd2,
    C_HALF  = 3'd3,
    C_DUAL  = 3'd4,
    C_HLONG = 3'd5,
    C_MSW   = 3'd6,
    C_MSWR  = 3'd7
  } mac_cls_e;

  typedef struct packed {
    mac_cls_e cls;
    logic     acc_en;
    logic     setf;
  } mac_ctl_t;

  localparam int CNT_W = 2;

  function automatic logic [CNT_W-1:0] pass_count(mac_cls_e c);
    case (c)
      C_HALF, C_DUAL:   return CNT_W'(1);
      C_ULONG, C_SLONG: return CNT_W'(3);
      default:          return CNT_W'(2);
    endcase
  endfunction

  function automatic logic two_beat(mac_cls_e c);
    return (c == C_ULONG) || (c == C_SLONG) || (c == C_HLONG);
  endfunction

endpackage

// File: rtl/mac_stage1.sv
module mac_stage1 import mac_pkg::*; #(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  mac_ctl_t      iss_ctl,
  input  logic [W-1:0]  iss_a,
  input  logic [W-1:0]  iss_b,
  input  logic [2*W-1:0] iss_acc,
  output logic          held,
  output logic          fwd_valid,
  output mac_ctl_t      fwd_ctl,
  output logic [2*W-1:0] fwd_prod,
  output logic [2*W-1:0] fwd_add
);
  localparam int DW = 2 * W;
  localparam int HW = W / 2;

  logic [CNT_W-1:0] cnt_q;
  mac_ctl_t         ctl_q;
  logic [W-1:0]     a_q, b_q;
  logic [DW-1:0]    acc_q;
  logic             take;

  assign take = iss_valid && !held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= 1'b0;
      cnt_q <= '0;
      ctl_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
    end else if (take) begin
      held  <= 1'b1;
      cnt_q <= pass_count(iss_ctl.cls) - CNT_W'(1);
      ctl_q <= iss_ctl;
      a_q   <= iss_a;
      b_q   <= iss_b;
      acc_q <= iss_acc;
    end else if (held) begin
      if (cnt_q == '0) held <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // two-beat results leave one pass early so the upper word trails by one cycle
  assign fwd_valid = held && (two_beat(ctl_q.cls) ? (cnt_q == CNT_W'(1)) : (cnt_q == '0));
  assign fwd_ctl   = ctl_q;

  logic [DW-1:0] a_z, b_z, a_s, b_s, al_s, bl_s, ah_s, bh_s;
  assign a_z  = {{W{1'b0}}, a_q};
  assign b_z  = {{W{1'b0}}, b_q};
  assign a_s  = {{W{a_q[W-1]}}, a_q};
  assign b_s  = {{W{b_q[W-1]}}, b_q};
  assign al_s = {{(DW-HW){a_q[HW-1]}}, a_q[HW-1:0]};
  assign bl_s = {{(DW-HW){b_q[HW-1]}}, b_q[HW-1:0]};
  assign ah_s = {{(DW-HW){a_q[W-1]}}, a_q[W-1:HW]};
  assign bh_s = {{(DW-HW){b_q[W-1]}}, b_q[W-1:HW]};

  always_comb begin
    case (ctl_q.cls)
      C_WORD, C_ULONG:       fwd_prod = a_z * b_z;
      C_SLONG, C_MSW, C_MSWR: fwd_prod = a_s * b_s;
      C_DUAL:                fwd_prod = al_s * bl_s + ah_s * bh_s;
      default:               fwd_prod = al_s * bl_s;
    endcase
    case (ctl_q.cls)
      C_MSW:                    fwd_add = '0;
      C_MSWR:                   fwd_add = DW'(1) << (W - 1);
      C_ULONG, C_SLONG, C_HLONG: fwd_add = ctl_q.acc_en ? acc_q : '0;
      default:                  fwd_add = ctl_q.acc_en ? {{W{1'b0}}, acc_q[W-1:0]} : '0;
    endcase
  end

  // R2
  // hold_pass_chk: a held operation with passes left stays held
  hold_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held && (cnt_q != '0) |=> held);

  // R2
  take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !held |=> held);

  // R3
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held && iss_valid && (cnt_q != '0) |=> $stable(ctl_q) && $stable(a_q) && $stable(b_q));

endmodule

// File: rtl/mac_accum.sv
module mac_accum import mac_pkg::*; #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  mac_ctl_t       in_ctl,
  input  logic [2*W-1:0] in_prod,
  input  logic [2*W-1:0] in_add,
  output logic           out_valid,
  output mac_ctl_t       out_ctl,
  output logic [2*W-1:0] out_sum
);
  localparam int DW = 2 * W;

  logic          m2_v;
  mac_ctl_t      m2_ctl;
  logic [DW-1:0] m2_prod, m2_add;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m2_v      <= 1'b0;
      m2_ctl    <= '0;
      m2_prod   <= '0;
      m2_add    <= '0;
      out_valid <= 1'b0;
      out_ctl   <= '0;
      out_sum   <= '0;
    end else begin
      m2_v      <= in_valid;
      m2_ctl    <= in_ctl;
      m2_prod   <= in_prod;
      m2_add    <= in_add;
      out_valid <= m2_v;
      out_ctl   <= m2_ctl;
      out_sum   <= m2_prod + m2_add;
    end
  end

  // R10
  stage_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> m2_v);

  // R10
  stage_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m2_v |=> out_valid);

endmodule

// File: rtl/mac_wb.sv
module mac_wb import mac_pkg::*; #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           res_valid,
  input  mac_ctl_t       res_ctl,
  input  logic [2*W-1:0] res_sum,
  output logic           wb_valid,
  output logic           wb_upper,
  output logic [W-1:0]   wb_data,
  output logic           flag_valid,
  output logic           flag_n,
  output logic           flag_z
);
  localparam int DW = 2 * W;

  logic         pend_v, pend_f, pend_n, pend_z;
  logic [W-1:0] pend_d;
  logic [W-1:0] r32;
  logic         hi_only, wide;

  assign hi_only = (res_ctl.cls == C_MSW) || (res_ctl.cls == C_MSWR);
  assign wide    = two_beat(res_ctl.cls);
  assign r32     = hi_only ? res_sum[DW-1:W] : res_sum[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0; wb_upper <= 1'b0; wb_data <= '0;
      flag_valid <= 1'b0; flag_n <= 1'b0; flag_z <= 1'b0;
      pend_v <= 1'b0; pend_f <= 1'b0; pend_n <= 1'b0; pend_z <= 1'b0; pend_d <= '0;
    end else if (res_valid) begin
      wb_valid <= 1'b1;
      wb_upper <= 1'b0;
      if (wide) begin
        wb_data    <= res_sum[W-1:0];
        flag_valid <= 1'b0;
        pend_v     <= 1'b1;
        pend_d     <= res_sum[DW-1:W];
        pend_f     <= res_ctl.setf;
        pend_n     <= res_sum[DW-1];
        pend_z     <= (res_sum == '0);
      end else begin
        wb_data    <= r32;
        flag_valid <= res_ctl.setf;
        flag_n     <= r32[W-1];
        flag_z     <= (r32 == '0);
        pend_v     <= 1'b0;
      end
    end else if (pend_v) begin
      wb_valid   <= 1'b1;
      wb_upper   <= 1'b1;
      wb_data    <= pend_d;
      flag_valid <= pend_f;
      flag_n     <= pend_n;
      flag_z     <= pend_z;
      pend_v     <= 1'b0;
    end else begin
      wb_valid   <= 1'b0;
      wb_upper   <= 1'b0;
      flag_valid <= 1'b0;
    end
  end

  // R10
  wb_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !pend_v);

  // R5
  upper_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |=> wb_valid && wb_upper);

  // R9
  flag_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_valid |-> wb_valid);

endmodule

// File: rtl/mac_pipe.sv
module mac_pipe import mac_pkg::*; #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_valid,
  output logic           iss_ready,
  input  logic [2:0]     iss_class,
  input  logic           iss_accum,
  input  logic           iss_setflags,
  input  logic [W-1:0]   iss_a,
  input  logic [W-1:0]   iss_b,
  input  logic [2*W-1:0] iss_acc,
  output logic           busy,
  output logic           wb_valid,
  output logic           wb_upper,
  output logic [W-1:0]   wb_data,
  output logic           flag_valid,
  output logic           flag_n,
  output logic           flag_z
);
  localparam int DW = 2 * W;

  mac_ctl_t      in_ctl, f_ctl, r_ctl;
  logic          held, f_v, r_v;
  logic [DW-1:0] f_prod, f_add, r_sum;

  assign in_ctl    = '{cls: mac_cls_e'(iss_class), acc_en: iss_accum, setf: iss_setflags};
  assign busy      = held;
  assign iss_ready = !held;

  mac_stage1 #(.W(W)) u_s1 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ctl(in_ctl),
    .iss_a(iss_a), .iss_b(iss_b), .iss_acc(iss_acc), .held(held),
    .fwd_valid(f_v), .fwd_ctl(f_ctl), .fwd_prod(f_prod), .fwd_add(f_add)
  );

  mac_accum #(.W(W)) u_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(f_v), .in_ctl(f_ctl),
    .in_prod(f_prod), .in_add(f_add),
    .out_valid(r_v), .out_ctl(r_ctl), .out_sum(r_sum)
  );

  mac_wb #(.W(W)) u_wb (
    .clk(clk), .rst_n(rst_n), .res_valid(r_v), .res_ctl(r_ctl), .res_sum(r_sum),
    .wb_valid(wb_valid), .wb_upper(wb_upper), .wb_data(wb_data),
    .flag_valid(flag_valid), .flag_n(flag_n), .flag_z(flag_z)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !wb_valid && !busy && !flag_valid);

  // R5
  upper_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_upper |-> wb_valid);

endmodule

// File: tb/mac_pipe_test.sv
module mac_pipe_test;
  localparam int W = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, iss_valid, iss_ready, iss_accum, iss_setflags, busy;
  logic [2:0] iss_class;
  logic [W-1:0] iss_a, iss_b, wb_data;
  logic [2*W-1:0] iss_acc;
  logic wb_valid, wb_upper, flag_valid, flag_n, flag_z;

  mac_pipe #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_class(iss_class), .iss_accum(iss_accum), .iss_setflags(iss_setflags),
    .iss_a(iss_a), .iss_b(iss_b), .iss_acc(iss_acc), .busy(busy),
    .wb_valid(wb_valid), .wb_upper(wb_upper), .wb_data(wb_data),
    .flag_valid(flag_valid), .flag_n(flag_n), .flag_z(flag_z)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0, free_at = 0, acc_cnt = 0;
  bit started = 0, done = 0;
  bit ev[64], eu[64], ef[64], en[64], ez[64];
  logic [31:0] ed[64];
  string et[64];

  task automatic chk(bit ok, string tag, string what, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", tag, what, cyc, act, exp);
    end
  endtask

  function automatic int passes(logic [2:0] c);
    case (c)
      3'd3, 3'd4: return 1;
      3'd1, 3'd2: return 3;
      default:    return 2;
    endcase
  endfunction

  function automatic bit wide(logic [2:0] c);
    return (c == 3'd1) || (c == 3'd2) || (c == 3'd5);
  endfunction

  function automatic string tag_of(logic [2:0] c);
    case (c)
      3'd0: return "R4";
      3'd1, 3'd2: return "R5";
      3'd3, 3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [63:0] model(logic [2:0] c, logic [31:0] a, logic [31:0] b,
                                        logic [63:0] acc, bit ae);
    longint unsigned ua, ub;
    longint sa, sb, sal, sbl, sah, sbh;
    logic [63:0] ad, ad32;
    ua = {32'b0, a}; ub = {32'b0, b};
    sa = longint'($signed(a)); sb = longint'($signed(b));
    sal = longint'($signed(a[15:0])); sbl = longint'($signed(b[15:0]));
    sah = longint'($signed(a[31:16])); sbh = longint'($signed(b[31:16]));
    ad = ae ? acc : 64'd0;
    ad32 = {32'b0, ad[31:0]};
    case (c)
      3'd0: return 64'(ua * ub) + ad32;
      3'd1: return 64'(ua * ub) + ad;
      3'd2: return 64'(sa * sb) + ad;
      3'd3: return 64'(sal * sbl) + ad32;
      3'd4: return 64'(sal * sbl + sah * sbh) + ad32;
      3'd5: return 64'(sal * sbl) + ad;
      3'd6: return 64'(sa * sb);
      default: return 64'(sa * sb) + 64'h8000_0000;
    endcase
  endfunction

  task automatic sched(int t, logic [31:0] d, bit u, bit f, bit n, bit z, string tag);
    ev[t % 64] = 1; ed[t % 64] = d; eu[t % 64] = u;
    ef[t % 64] = f; en[t % 64] = n; ez[t % 64] = z; et[t % 64] = tag;
  endtask

  // monitor and reference model, one time step after each falling edge
  always begin
    bit rdy;
    int idx, c, p;
    logic [63:0] r;
    logic [31:0] r32;
    @(negedge clk); #1;
    if (started && !done) begin
      rdy = (cyc >= free_at);
      chk(iss_ready === rdy && busy === !rdy, "R2", "ready/busy", {iss_ready, busy}, {rdy, !rdy});
      idx = cyc % 64;
      if (ev[idx]) begin
        chk(wb_valid === 1'b1 && wb_upper === eu[idx] && wb_data === ed[idx], et[idx], "beat",
            {wb_valid, wb_upper, wb_data}, {1'b1, eu[idx], ed[idx]});
        // R9 flag beat
        chk(flag_valid === ef[idx] && (!ef[idx] || (flag_n === en[idx] && flag_z === ez[idx])),
            "R9", "flags", {flag_valid, flag_n, flag_z}, {ef[idx], en[idx], ez[idx]});
        ev[idx] = 0;
      end else begin
        // R10 no beat outside its slot
        chk(wb_valid === 1'b0 && flag_valid === 1'b0, "R10", "idle", {wb_valid, flag_valid}, 0);
      end
      if (iss_valid && rdy) begin
        c = cyc + 1;
        p = passes(iss_class);
        free_at = c + p;
        acc_cnt++;
        r = model(iss_class, iss_a, iss_b, iss_acc, iss_accum);
        if (wide(iss_class)) begin
          sched(c + p + 1, r[31:0], 0, 0, 0, 0, tag_of(iss_class));
          sched(c + p + 2, r[63:32], 1, iss_setflags, r[63], r == 64'd0, tag_of(iss_class));
        end else begin
          r32 = (iss_class >= 3'd6) ? r[63:32] : r[31:0];
          sched(c + p + 2, r32, 0, iss_setflags, r32[31], r32 == 32'd0, tag_of(iss_class));
        end
      end
    end
  end

  // call at a falling edge; returns at the falling edge after acceptance
  task automatic issue_op(logic [2:0] c, bit ae, bit sf, logic [31:0] a, logic [31:0] b,
                          logic [63:0] acc);
    int n0;
    n0 = acc_cnt;
    iss_valid = 1; iss_class = c; iss_accum = ae; iss_setflags = sf;
    iss_a = a; iss_b = b; iss_acc = acc;
    while (acc_cnt == n0) @(negedge clk);
  endtask

  task automatic idle(int n);
    iss_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'd0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h0000_8000;
      default: return $urandom;
    endcase
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    void'($urandom(32'd4021));
    rst_n = 0; iss_valid = 0; iss_class = 0; iss_accum = 0; iss_setflags = 0;
    iss_a = 0; iss_b = 0; iss_acc = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 during reset
    chk(iss_ready === 1 && busy === 0 && wb_valid === 0 && flag_valid === 0, "R1", "reset",
        {iss_ready, busy, wb_valid, flag_valid}, 4'b1000);
    @(negedge clk);
    rst_n = 1;
    started = 1;
    // R4 word multiply-accumulate with flags, and without accumulation
    issue_op(3'd0, 1, 1, 32'd3, 32'd5, 64'd7);
    issue_op(3'd0, 0, 1, 32'hFFFF_FFFF, 32'd2, 64'hFFFF);
    issue_op(3'd0, 0, 1, 32'd0, 32'd99, 64'd0);
    idle(6);
    // R5 unsigned and signed long, R3 offers while busy
    issue_op(3'd1, 1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd1);
    iss_class = 3'd3; iss_a = 32'd11; iss_b = 32'd13;
    @(negedge clk); @(negedge clk);
    iss_valid = 0;
    issue_op(3'd2, 0, 1, 32'h8000_0000, 32'h0000_0003, 64'd5);
    issue_op(3'd1, 0, 1, 32'h0001_0000, 32'h0001_0000, 64'd0);
    // R6 halfword and dual right behind a long op (R10)
    issue_op(3'd3, 1, 1, 32'h1234_FFFE, 32'h0000_0003, 64'd10);
    issue_op(3'd4, 0, 1, 32'hFFFF_0002, 32'h0004_0005, 64'd0);
    // R7 halfword into a 64-bit accumulator
    issue_op(3'd5, 1, 1, 32'h0000_8000, 32'h0000_7FFF, 64'h0000_0001_0000_0000);
    issue_op(3'd3, 0, 0, 32'd2, 32'd2, 64'd0);
    idle(4);
    // R8 most-significant word, rounding boundary, accumulate bit ignored
    issue_op(3'd6, 1, 1, 32'h0001_0000, 32'h0000_8000, 64'hFFFF_FFFF_FFFF_FFFF);
    issue_op(3'd7, 1, 1, 32'h0001_0000, 32'h0000_8000, 64'hFFFF_FFFF_FFFF_FFFF);
    issue_op(3'd7, 0, 1, 32'h8000_0000, 32'h8000_0000, 64'd0);
    idle(6);
    // random mix
    for (int i = 0; i < 600; i++) begin
      issue_op(3'($urandom % 8), 1'($urandom % 2), 1'($urandom % 2), pick(), pick(),
               {pick(), pick()});
      if ($urandom % 4 == 0) idle(1 + $urandom % 4);
    end
    idle(12);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
      summary();
      $finish;
    end
  end

endmodule